// File: doc/BRIEF.md
# Dual-Address Pass-Through Synchronous RAM

This block is a synchronous word memory with two fully independent access ports, named X and Y. Each port has its own address, write data, read data, write strobe and a pair of chip selects. Every clock cycle, each port can read, write, or forward data. In a forwarding (pass-through) cycle, the write data presented on one port appears on the other port's read output without passing through the array. This lets a system move a word straight from one bus to the other while the array stays free for the opposite port.

All controls, addresses and write data are registered on the rising clock edge. Read and forwarded data are then loaded into a per-port output register one edge later. Two fixed rules settle cycles in which both ports hit the same word. First, a read always sees the contents from before any write in that cycle. Second, when both ports write the same word, port Y's data is the one stored. Each port also has an output enable that acts without the clock. Bidirectional pads are modelled as separate data-in, data-out and drive-enable signals.

Top module: `xy_pass_ram`

## Requirements
- R1: Addresses, write data and controls are captured on a rising edge. Read data for that request appears on the port's read output after the following rising edge, two edges after it was presented, and not after the first.
- R2: A port is selected only when its active-low select is 0 and its active-high select is 1. A port that is not selected keeps its output value, writes nothing and cannot take part in a pass-through.
- R3: A selected port with its active-low write strobe at 0 stores its write data at its own address. Its own output register keeps its previous value.
- R4: When both ports are selected and X's active-low pass control is 0, port X's write data appears on Y's read output two edges later.
- R5: When both ports are selected and Y's active-low pass control is 0, port Y's write data appears on X's read output two edges later. Both directions may be used in the same cycle.
- R6: A port reads only when it is selected, its write strobe is 1 and both ports' pass controls are 1. A pass-through into a port overrides that port's read, and a write on the receiving port still reaches the array.
- R7: Two reads of the same address in one cycle both return the stored word.
- R8: When one port writes and the other reads the same address in one cycle, the read returns the word stored before the write.
- R9: When both ports write the same address in one cycle, the word left in the array is port Y's data.
- R10: A port's drive-enable output is 0 whenever its active-low output enable is 1, with no clock edge needed. When the output enable is 0, the output register drives the port.
- R11: While reset is asserted, both drive-enables are 0 and both read outputs are 0. Drive-enables stay 0 after reset is released, until the first rising edge that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_addr | input | ADDR_W | Port X word address |
| x_wdata | input | DATA_W | Port X write / forward data |
| x_sel_n | input | 1 | Port X select, active low |
| x_sel | input | 1 | Port X select, active high |
| x_wr_n | input | 1 | Port X write strobe, active low |
| x_pass_n | input | 1 | Forward X data to Y output, active low |
| x_oe_n | input | 1 | Port X output enable, active low, unclocked |
| x_rdata | output | DATA_W | Port X output register |
| x_drive | output | 1 | Port X pad drive enable |
| y_addr | input | ADDR_W | Port Y word address |
| y_wdata | input | DATA_W | Port Y write / forward data |
| y_sel_n | input | 1 | Port Y select, active low |
| y_sel | input | 1 | Port Y select, active high |
| y_wr_n | input | 1 | Port Y write strobe, active low |
| y_pass_n | input | 1 | Forward Y data to X output, active low |
| y_oe_n | input | 1 | Port Y output enable, active low, unclocked |
| y_rdata | output | DATA_W | Port Y output register |
| y_drive | output | 1 | Port Y pad drive enable |

## Verification
Most internal faults surface on a read output exactly two edges after the request that exposes them. A wrong select decode, wrong pass priority or swapped forwarding path shows up as a stale or foreign word in that sample. A wrong order of same-address writes, or a write that lands despite a deselect, stays hidden in the array until a later read of that address. For that reason, each write corner case is followed by a readback. Drive-enable faults show up at once, with no clock edge, when the output enable toggles, and in the window just after reset is released.

// File: rtl/xyr_pkg.sv
package xyr_pkg;
   // Port index used across the generate loops
   localparam int PORT_X = 0;
   localparam int PORT_Y = 1;
   localparam int NPORTS = 2;

   // Decoded, active-high request captured per port
   typedef struct packed {
      logic en;    // both selects in their active state
      logic wr;    // write strobe asserted
      logic pass;  // forward this port's data to the other port
   } req_t;

   function automatic req_t decode_req(input logic sel_n, input logic sel,
                                       input logic wr_n, input logic pass_n);
      req_t r;
      r.en   = ~sel_n & sel;
      r.wr   = ~wr_n;
      r.pass = ~pass_n;
      return r;
   endfunction
endpackage

// File: rtl/xyr_in_reg.sv
module xyr_in_reg
   import xyr_pkg::*;
#(
   parameter int DATA_W = 36,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              sel_n_i,
   input  logic              sel_i,
   input  logic              wr_n_i,
   input  logic              pass_n_i,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output req_t              req_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         req_q   <= '0;
      end else begin
         addr_q  <= addr_i;
         wdata_q <= wdata_i;
         req_q   <= decode_req(sel_n_i, sel_i, wr_n_i, pass_n_i);
      end
   end
endmodule

// File: rtl/xyr_array.sv
module xyr_array #(
   parameter int DATA_W = 36,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              wr_x,
   input  logic [ADDR_W-1:0] addr_x,
   input  logic [DATA_W-1:0] data_x,
   input  logic              wr_y,
   input  logic [ADDR_W-1:0] addr_y,
   input  logic [DATA_W-1:0] data_y,
   output logic [DATA_W-1:0] rd_x,
   output logic [DATA_W-1:0] rd_y
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   // Unclocked read: the output registers sample it at the same edge
   // that commits writes, so every read sees pre-write contents.
   assign rd_x = mem[addr_x];
   assign rd_y = mem[addr_y];

   // Y is updated after X, so Y's value survives a same-address collision.
   always_ff @(posedge clk) begin
      if (wr_x) mem[addr_x] <= data_x;
      if (wr_y) mem[addr_y] <= data_y;
   end
endmodule

// File: rtl/xyr_out_reg.sv
module xyr_out_reg #(
   parameter int DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pass_in,
   input  logic [DATA_W-1:0] pass_data,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              live,
   input  logic              oe_n,
   output logic [DATA_W-1:0] q,
   output logic              drive
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (pass_in) q <= pass_data;
      else if (rd_en)   q <= rd_data;
   end

   assign drive = live & ~oe_n;
endmodule

// File: rtl/xy_pass_ram.sv
module xy_pass_ram
   import xyr_pkg::*;
#(
   parameter int DATA_W = 36,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] x_addr,
   input  logic [DATA_W-1:0] x_wdata,
   input  logic              x_sel_n,
   input  logic              x_sel,
   input  logic              x_wr_n,
   input  logic              x_pass_n,
   input  logic              x_oe_n,
   output logic [DATA_W-1:0] x_rdata,
   output logic              x_drive,
   input  logic [ADDR_W-1:0] y_addr,
   input  logic [DATA_W-1:0] y_wdata,
   input  logic              y_sel_n,
   input  logic              y_sel,
   input  logic              y_wr_n,
   input  logic              y_pass_n,
   input  logic              y_oe_n,
   output logic [DATA_W-1:0] y_rdata,
   output logic              y_drive
);
   localparam int MAX_ADDR_W = 20;

   if (DATA_W < 1) begin : g_bad_data_w
      $error("xy_pass_ram: DATA_W must be at least 1");
   end
   if (ADDR_W < 1 || ADDR_W > MAX_ADDR_W) begin : g_bad_addr_w
      $error("xy_pass_ram: ADDR_W out of range");
   end

   // Per-port pin bundles gathered into arrays indexed by port
   logic [ADDR_W-1:0] pin_addr  [NPORTS];
   logic [DATA_W-1:0] pin_wdata [NPORTS];
   logic              pin_sel_n [NPORTS];
   logic              pin_sel   [NPORTS];
   logic              pin_wr_n  [NPORTS];
   logic              pin_pass_n[NPORTS];
   logic              pin_oe_n  [NPORTS];

   assign pin_addr[PORT_X]   = x_addr;   assign pin_addr[PORT_Y]   = y_addr;
   assign pin_wdata[PORT_X]  = x_wdata;  assign pin_wdata[PORT_Y]  = y_wdata;
   assign pin_sel_n[PORT_X]  = x_sel_n;  assign pin_sel_n[PORT_Y]  = y_sel_n;
   assign pin_sel[PORT_X]    = x_sel;    assign pin_sel[PORT_Y]    = y_sel;
   assign pin_wr_n[PORT_X]   = x_wr_n;   assign pin_wr_n[PORT_Y]   = y_wr_n;
   assign pin_pass_n[PORT_X] = x_pass_n; assign pin_pass_n[PORT_Y] = y_pass_n;
   assign pin_oe_n[PORT_X]   = x_oe_n;   assign pin_oe_n[PORT_Y]   = y_oe_n;

   logic [ADDR_W-1:0] addr_q  [NPORTS];
   logic [DATA_W-1:0] wdata_q [NPORTS];
   req_t              req_q   [NPORTS];
   logic [DATA_W-1:0] arr_rd  [NPORTS];
   logic              wr_go   [NPORTS];
   logic              pass_to [NPORTS];
   logic              rd_go   [NPORTS];
   logic [DATA_W-1:0] out_q   [NPORTS];
   logic              out_drv [NPORTS];

   // Pads stay undriven until one clock edge has passed after reset
   logic live_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= 1'b0;
      else        live_q <= 1'b1;
   end

   logic both_en;
   logic any_pass;
   assign both_en  = req_q[PORT_X].en & req_q[PORT_Y].en;
   assign any_pass = req_q[PORT_X].pass | req_q[PORT_Y].pass;

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      localparam int OTHER = NPORTS - 1 - p;

      xyr_in_reg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_in (
         .clk      (clk),
         .rst_n    (rst_n),
         .addr_i   (pin_addr[p]),
         .wdata_i  (pin_wdata[p]),
         .sel_n_i  (pin_sel_n[p]),
         .sel_i    (pin_sel[p]),
         .wr_n_i   (pin_wr_n[p]),
         .pass_n_i (pin_pass_n[p]),
         .addr_q   (addr_q[p]),
         .wdata_q  (wdata_q[p]),
         .req_q    (req_q[p])
      );

      // The other port forwards into this one only when both are selected
      assign pass_to[p] = both_en & req_q[OTHER].pass;
      assign wr_go[p]   = req_q[p].en & req_q[p].wr;
      assign rd_go[p]   = req_q[p].en & ~req_q[p].wr & ~any_pass;

      xyr_out_reg #(.DATA_W(DATA_W)) u_out (
         .clk       (clk),
         .rst_n     (rst_n),
         .pass_in   (pass_to[p]),
         .pass_data (wdata_q[OTHER]),
         .rd_en     (rd_go[p]),
         .rd_data   (arr_rd[p]),
         .live      (live_q),
         .oe_n      (pin_oe_n[p]),
         .q         (out_q[p]),
         .drive     (out_drv[p])
      );
   end

   xyr_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
      .clk    (clk),
      .wr_x   (wr_go[PORT_X]),
      .addr_x (addr_q[PORT_X]),
      .data_x (wdata_q[PORT_X]),
      .wr_y   (wr_go[PORT_Y]),
      .addr_y (addr_q[PORT_Y]),
      .data_y (wdata_q[PORT_Y]),
      .rd_x   (arr_rd[PORT_X]),
      .rd_y   (arr_rd[PORT_Y])
   );

   assign x_rdata = out_q[PORT_X];
   assign y_rdata = out_q[PORT_Y];
   assign x_drive = out_drv[PORT_X];
   assign y_drive = out_drv[PORT_Y];
endmodule

// File: rtl/xyr_ram_chk.sv
module xyr_ram_chk #(
   parameter int DATA_W = 36,
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] x_addr,
   input logic [DATA_W-1:0] x_wdata,
   input logic              x_sel_n,
   input logic              x_sel,
   input logic              x_wr_n,
   input logic              x_pass_n,
   input logic              x_oe_n,
   input logic [DATA_W-1:0] x_rdata,
   input logic              x_drive,
   input logic [ADDR_W-1:0] y_addr,
   input logic [DATA_W-1:0] y_wdata,
   input logic              y_sel_n,
   input logic              y_sel,
   input logic              y_wr_n,
   input logic              y_pass_n,
   input logic              y_oe_n,
   input logic [DATA_W-1:0] y_rdata,
   input logic              y_drive
);
   logic x_on, y_on;
   assign x_on = ~x_sel_n & x_sel;
   assign y_on = ~y_sel_n & y_sel;

   // R11
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> (!x_drive && !y_drive));

   // R10
   oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (x_oe_n |-> !x_drive) and (y_oe_n |-> !y_drive));

   // R4
   pass_x_to_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (x_on && y_on && !x_pass_n) |=> ##1 (y_rdata == $past(x_wdata, 2)));

   // R5
   pass_y_to_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (x_on && y_on && !y_pass_n) |=> ##1 (x_rdata == $past(y_wdata, 2)));

   // R2
   deselect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !x_on |=> ##1 $stable(x_rdata));
endmodule

bind xy_pass_ram xyr_ram_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/xy_pass_ram_bench.sv
module xy_pass_ram_bench;
   localparam int DW = 36;
   localparam int AW = 6;
   localparam int NV = 17;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] x_addr = '0, y_addr = '0;
   logic [DW-1:0] x_wdata = '0, y_wdata = '0;
   logic x_sel_n = 1'b1, x_sel = 1'b0, x_wr_n = 1'b1, x_pass_n = 1'b1, x_oe_n = 1'b0;
   logic y_sel_n = 1'b1, y_sel = 1'b0, y_wr_n = 1'b1, y_pass_n = 1'b1, y_oe_n = 1'b0;
   logic [DW-1:0] x_rdata, y_rdata;
   logic x_drive, y_drive;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   xy_pass_ram #(.DATA_W(DW), .ADDR_W(AW)) u_xy_pass_ram (.*);

   typedef struct packed {
      logic xsn, xs, xwn, xpn; logic [AW-1:0] xa; logic [DW-1:0] xd;
      logic ysn, ys, ywn, ypn; logic [AW-1:0] ya; logic [DW-1:0] yd;
      logic [DW-1:0] ex, ey; logic [7:0] tag;
   } vec_t;

   // select: sel_n=0 & sel=1; wr_n=0 writes; pass_n=0 forwards to the other port
   localparam vec_t VEC [NV] = '{
      '{0,1,0,1, 6'd3, 36'h111, 0,1,0,1, 6'd5, 36'h222, 36'h0,   36'h0,   8'd3}, // R3 writes, outputs hold
      '{0,1,1,1, 6'd5, 36'h0,   0,1,1,1, 6'd3, 36'h0,   36'h222, 36'h111, 8'd1}, // R1 cross reads
      '{0,1,1,1, 6'd3, 36'h0,   0,1,1,1, 6'd3, 36'h0,   36'h111, 36'h111, 8'd7}, // R7 same-address reads
      '{0,1,0,1, 6'd3, 36'h333, 0,1,1,1, 6'd3, 36'h0,   36'h111, 36'h111, 8'd8}, // R8 Y reads old
      '{1,1,1,1, 6'd0, 36'h0,   0,1,1,1, 6'd3, 36'h0,   36'h111, 36'h333, 8'd2}, // R2 X off, Y sees new
      '{0,1,1,1, 6'd5, 36'h0,   0,1,0,1, 6'd5, 36'h555, 36'h222, 36'h333, 8'd8}, // R8 X reads old
      '{0,1,0,1, 6'd9, 36'hAAA, 0,1,0,1, 6'd9, 36'hBBB, 36'h222, 36'h333, 8'd9}, // R9 double write
      '{0,1,1,1, 6'd9, 36'h0,   0,1,1,1, 6'd9, 36'h0,   36'hBBB, 36'hBBB, 8'd9}, // R9 Y data kept
      '{0,1,1,0, 6'd0, 36'hC0C, 0,1,1,1, 6'd3, 36'h0,   36'hBBB, 36'hC0C, 8'd4}, // R4 R6 X to Y
      '{0,1,1,1, 6'd3, 36'h0,   0,1,1,0, 6'd0, 36'hD0D, 36'hD0D, 36'hC0C, 8'd5}, // R5 R6 Y to X
      '{0,1,1,0, 6'd0, 36'h1E1, 0,1,1,0, 6'd0, 36'h2F2, 36'h2F2, 36'h1E1, 8'd5}, // R5 both ways
      '{0,1,1,0, 6'd0, 36'h999, 1,0,1,1, 6'd3, 36'h0,   36'h2F2, 36'h1E1, 8'd2}, // R2 no pass when Y off
      '{0,0,0,1, 6'd3, 36'hFFF, 0,1,1,1, 6'd3, 36'h0,   36'h2F2, 36'h333, 8'd2}, // R2 X sel low, no write
      '{0,1,1,1, 6'd3, 36'h0,   1,1,1,1, 6'd0, 36'h0,   36'h333, 36'h333, 8'd2}, // R2 readback untouched
      '{0,1,1,0, 6'd0, 36'h0AB, 0,1,0,1, 6'd5, 36'h777, 36'h333, 36'h0AB, 8'd6}, // R6 pass plus Y write
      '{0,1,1,1, 6'd5, 36'h0,   0,1,1,0, 6'd0, 36'hCDE, 36'hCDE, 36'h0AB, 8'd6}, // R6 pass beats X read
      '{0,1,1,1, 6'd5, 36'h0,   1,0,1,1, 6'd0, 36'h0,   36'h777, 36'h0AB, 8'd3}  // R3 Y write landed
   };

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      x_sel_n = 1'b1; x_sel = 1'b0; x_wr_n = 1'b1; x_pass_n = 1'b1;
      y_sel_n = 1'b1; y_sel = 1'b0; y_wr_n = 1'b1; y_pass_n = 1'b1;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(20 * 2000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 state during reset
      check("R11", {34'b0, x_drive, y_drive}, '0);
      check("R11", x_rdata | y_rdata, '0);
      rst_n = 1'b1;
      #2;
      check("R11", {34'b0, x_drive, y_drive}, '0);
      tick();
      check("R11", {34'b0, x_drive, y_drive}, 36'd3);

      for (int i = 0; i < NV; i++) begin
         x_sel_n = VEC[i].xsn; x_sel = VEC[i].xs; x_wr_n = VEC[i].xwn; x_pass_n = VEC[i].xpn;
         x_addr = VEC[i].xa; x_wdata = VEC[i].xd;
         y_sel_n = VEC[i].ysn; y_sel = VEC[i].ys; y_wr_n = VEC[i].ywn; y_pass_n = VEC[i].ypn;
         y_addr = VEC[i].ya; y_wdata = VEC[i].yd;
         tick();
         idle();
         tick();
         check($sformatf("R%0d x row%0d", VEC[i].tag, i), x_rdata, VEC[i].ex);
         check($sformatf("R%0d y row%0d", VEC[i].tag, i), y_rdata, VEC[i].ey);
      end

      // R1 latency: nothing after the first edge, data after the second
      x_sel_n = 1'b0; x_sel = 1'b1; x_addr = 6'd9;
      tick();
      idle();
      check("R1 one edge", x_rdata, 36'h777);
      tick();
      check("R1 two edges", x_rdata, 36'hBBB);

      // R10 output enable acts without a clock
      x_oe_n = 1'b1;
      #2;
      check("R10 x off", {35'b0, x_drive}, '0);
      check("R10 y on", {35'b0, y_drive}, 36'd1);
      check("R10 data kept", x_rdata, 36'hBBB);
      x_oe_n = 1'b0;
      #2;
      check("R10 x back", {35'b0, x_drive}, 36'd1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule